// File: doc/BRIEF.md
# RAM-Based Wide Delay Line with Pseudo-Random Addressing

This block delays a wide data word by a fixed number of enabled clocks. Storage is a set of small synchronous RAMs, not a flip-flop chain. On each enabled clock the block reads the oldest word at the current address and writes the incoming word to that same address. The address then steps along the sequence of a maximal-length shift-register counter, extended so that it also visits the all-zero state. With the default 4-bit address, the delay is exactly 16 enabled clocks on a 256-bit word.

The word is divided into lanes. Each lane has its own RAM slice and its own private address counter, so no single address net has to reach all the RAM cells. The lane counters share no logic. They stay in step because they all leave reset on the same edge and advance on the same enable. The default is 16 lanes of 16 bits. A 32-lane, 8-bit setting shortens the address nets further for higher clock rates. Elaboration stops with an error if the word width is not an exact multiple of the lane width.

The data path has no back-pressure. `en` is a plain qualifier, and the block accepts a word on every clock where it is high. The output is registered and changes only on enabled clocks or on reset. RAM contents survive reset, so the output is meaningful from the seventeenth enabled clock after reset onward.

Top module: `lfsr_delay_line`

## Requirements
- R1: A clock edge with `rst` high drives `dout` to all zeros, whatever the value of `en`.
- R2: With `rst` low, an edge with `en` high sets `dout` to the `din` value accepted 16 enabled edges earlier. This holds from the 17th enabled edge after reset. The delay is 2^ADDR_W enabled edges, because each lane address counter passes through every state, including zero, before it repeats.
- R3: An edge with `en` low and `rst` low leaves `dout`, the RAM contents and every lane address unchanged. The delay therefore counts only enabled edges.
- R4: A reset in the middle of a stream returns every lane address counter to the seed value without clearing the RAM. Exact delay behaviour resumes from the 17th enabled edge after reset.
- R5: A word presented on an edge with both `rst` and `en` high is not stored. It never appears at `dout`.
- R6: Bit k of `din` reappears at bit k of `dout`, and no data moves across lanes. All lane address counters hold equal values on every cycle. The setting LANE_W=8, which gives 32 lanes, has the same port behaviour as the default setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accept `din` and advance the line on this edge |
| din | input | DATA_W | Input word |
| dout | output | DATA_W | Delayed word (registered) |

## Verification
The bench predicts every output with a 16-entry reference history. It compares the default layout and the 32-lane layout side by side.

Several faults are targeted directly:
- **Counter that skips the zero state.** This gives a 15-edge delay, which shows up as mismatches as soon as the line fills.
- **Address that advances while `en` is low.** This corrupts the data order after an idle stretch.
- **Reset that lets a simultaneous `en` write through.** This leaks the reset-cycle word into the stream.
- **Counter seed not reloaded on a mid-stream reset.** This mis-aligns the second stream.

A walking-one pattern exposes any lane or bit swap.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Feedback tap mask for a left-shifting maximal-length counter.
  // Bit i set means state[i] enters the XOR.
  function automatic logic [7:0] tap_mask(input int aw);
    case (aw)
      2:       return 8'b0000_0011;
      3:       return 8'b0000_0110;
      4:       return 8'b0000_1100;
      5:       return 8'b0001_0100;
      6:       return 8'b0011_0000;
      7:       return 8'b0110_0000;
      8:       return 8'b1011_1000;
      default: return 8'b0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/dl_addr_gen.sv
module dl_addr_gen
  import dl_pkg::*;
#(
  parameter int unsigned    AW   = 4,
  parameter logic [AW-1:0]  SEED = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] TAPS = AW'(tap_mask(AW));

  logic [AW-1:0] state;
  logic          fb;

  // The zero-detect term splices the all-zero state into the cycle,
  // giving a full 2^AW period.
  always_comb begin
    fb = (^(state & TAPS)) ^ (state[AW-2:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= {state[AW-2:0], fb};
  end

  assign addr = state;

  // R4
  seed_load_chk: assert property (@(posedge clk) rst |=> addr == SEED);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(addr));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> addr != $past(addr));

endmodule

// File: rtl/dl_lane_ram.sv
module dl_lane_ram #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Write port: storage is never cleared, and reset blocks the write.
  always_ff @(posedge clk) begin
    if (we && !rst) mem[addr] <= wdata;
  end

  // Read port: returns the old word at this address (read before write).
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (we) rdata <= mem[addr];
  end

  // R1
  rd_clear_chk: assert property (@(posedge clk) rst |=> rdata == '0);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));

endmodule

// File: rtl/dl_lane.sv
module dl_lane #(
  parameter int unsigned   W    = 16,
  parameter int unsigned   AW   = 4,
  parameter logic [AW-1:0] SEED = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [AW-1:0] addr
);

  dl_addr_gen #(.AW(AW), .SEED(SEED)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .step (en),
    .addr (addr)
  );

  dl_lane_ram #(.W(W), .AW(AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (en),
    .addr  (addr),
    .wdata (din),
    .rdata (dout)
  );

endmodule

// File: rtl/lfsr_delay_line.sv
module lfsr_delay_line #(
  parameter int unsigned DATA_W = 256,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SEED   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned   LANES  = DATA_W / LANE_W;
  localparam logic [ADDR_W-1:0] SEED_V = ADDR_W'(SEED);

  if (DATA_W % LANE_W != 0) begin : g_width_bad
    $fatal(1, "DATA_W must be a multiple of LANE_W");
  end

  if (ADDR_W < 2 || ADDR_W > 8) begin : g_addr_bad
    $fatal(1, "ADDR_W must lie in 2..8");
  end

  logic [ADDR_W-1:0] lane_addr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dl_lane #(.W(LANE_W), .AW(ADDR_W), .SEED(SEED_V)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .din  (din [g*LANE_W +: LANE_W]),
      .dout (dout[g*LANE_W +: LANE_W]),
      .addr (lane_addr[g])
    );

    if (g > 0) begin : g_sync
      // R6
      lanes_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
        lane_addr[g] == lane_addr[0]);
    end
  end

endmodule

// File: tb/sim_lfsr_delay_line.sv
module sim_lfsr_delay_line;

  localparam int W = 256;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout0, dout1;

  int  checks   = 0;
  int  errors   = 0;
  int  pushes   = 0;
  bit  finished = 1'b0;

  logic [W-1:0] hist [32];
  logic [W-1:0] prev0, prev1;

  always #2 clk = ~clk;

  lfsr_delay_line #(.DATA_W(W), .LANE_W(16)) u0 (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout0));

  lfsr_delay_line #(.DATA_W(W), .LANE_W(8)) u1 (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout1));

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] w;
    for (int i = 0; i < W/32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  // Reference model: the word accepted D enabled edges before push index i.
  function automatic logic [W-1:0] expected_at(int i);
    return hist[(i - D) % 32];
  endfunction

  task automatic check(string req, string who, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, who, act, exp);
    end
  endtask

  task automatic cycle(bit r, bit e, logic [W-1:0] d, string tag);
    @(negedge clk);
    rst = r; en = e; din = d;
    prev0 = dout0; prev1 = dout1;
    @(posedge clk);
    #1;
    if (r) begin
      pushes = 0;
      check("R1", "u0", dout0, '0);
      check("R1", "u1", dout1, '0);
    end else if (e) begin
      hist[pushes % 32] = d;
      if (pushes >= D) begin
        check(tag, "u0", dout0, expected_at(pushes));
        check(tag, "u1", dout1, expected_at(pushes));
      end
      pushes++;
    end else begin
      check("R3", "u0", dout0, prev0);
      check("R3", "u1", dout1, prev1);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    void'($urandom(32'd2024));

    // R1: reset state; R3: idle after reset holds zero
    for (int i = 0; i < 3; i++) cycle(1, 0, '0, "R1");
    for (int i = 0; i < 3; i++) cycle(0, 0, rand_word(), "R3");

    // R6: walking one exposes any lane or bit swap
    for (int i = 0; i < 48; i++) cycle(0, 1, (W'(1) << ((i * 37) % W)), "R6");

    // R2: back-to-back enabled stream
    for (int i = 0; i < 40; i++) cycle(0, 1, rand_word(), "R2");

    // R2/R3: random enable pattern
    for (int i = 0; i < 300; i++) cycle(0, ($urandom % 10) < 7, rand_word(), "R2");

    // R5: reset with en high must not store the word
    cycle(1, 1, {W/32{32'hDEAD_BEEF}}, "R5");
    cycle(1, 1, {W/32{32'hCAFE_F00D}}, "R5");

    // R4: stream resumes with exact delay after mid-stream reset
    for (int i = 0; i < 60; i++) cycle(0, ($urandom % 4) != 0, rand_word(), "R4/R5");

    // R3: long idle stretch, then more traffic
    for (int i = 0; i < 20; i++) cycle(0, 0, rand_word(), "R3");
    for (int i = 0; i < 200; i++) cycle(0, ($urandom % 10) < 6, rand_word(), "R2");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule